// File: doc/BRIEF.md
# Delayed Read Request Capture

This block sits on the target side of a bus bridge and turns every read it claims into a delayed transaction. In the address phase it latches the address, the bus command and the address parity. In the cycle the initiator first signals ready for data it takes the byte enables. It then records the request in a free delayed-transaction entry and ends the initiator's cycle with a target retry. Each entry forwards its request toward the opposite bus through a valid/ready port, tagged with the entry number.

The initiator keeps repeating the same read. A repeat is compared against the stored entries on address, command and byte enables. While the entry waits for its completion, the repeat is retried. Once the completion has arrived, the next matching repeat receives the read data, or the target-abort or master-abort status, and the entry is freed. A completed entry that is not collected within a parameterised number of clocks is dropped. When every entry is busy, a new read is retried and nothing is recorded.

Top module: `dr_read_capture`

## Requirements
- R1: A read that matches no entry is answered with a one-cycle `t_retry` in the cycle after its `t_irdy` cycle. Its request then appears on the `m_req_*` outputs with the address, command and parity latched when `t_start` was high.
- R2: The byte enables stored and forwarded are those present on `t_be` in the `t_irdy` cycle, not those present in the address phase.
- R3: The entry number goes out on `m_req_tag`, choosing the lowest-numbered free entry. While `m_req_valid` is high and `m_req_ready` is low, the valid, tag and request fields hold steady. Each recorded request is offered exactly once.
- R4: A repeat whose address, command and byte enables all equal a waiting entry is answered with `t_retry`, and no further request is offered.
- R5: A completion tagged with a waiting entry with `c_status`=2'b00 makes the next matching repeat answer `t_ack` with `c_data` on `t_rdata`. This frees the entry, so a further identical read is treated as new.
- R6: `c_status`=2'b01 makes the next matching repeat answer `t_tabort`, and 2'b10 makes it answer `t_mabort`. Either answer frees the entry.
- R7: A read differing in address, command or byte enables from every entry takes another entry. When all `NENT` entries are busy it is retried and no request is offered.
- R8: A completed entry not collected within `DISCARD_LIMIT` clocks of its completion is dropped. A later identical read is retried and offered as a new request.
- R9: When a completion and a matching repeat arrive in the same cycle, the repeat is retried, and the following repeat receives the completion.
- R10: Each attempt gets exactly one of `t_retry`, `t_ack`, `t_tabort`, `t_mabort`, and never more than one at once. After reset all four and `m_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_start | input | 1 | Address phase of a claimed read |
| t_addr | input | AW | Read address (address phase) |
| t_cmd | input | 4 | Bus command (address phase) |
| t_par | input | 1 | Address parity (address phase) |
| t_irdy | input | 1 | Initiator ready, first data phase |
| t_be | input | 4 | Byte enables, sampled with t_irdy |
| t_retry | output | 1 | Terminate attempt with retry |
| t_ack | output | 1 | Deliver read data |
| t_tabort | output | 1 | Pass on target abort |
| t_mabort | output | 1 | Pass on master abort |
| t_rdata | output | DW | Read data with t_ack |
| m_req_valid | output | 1 | Request offered to opposite bus |
| m_req_ready | input | 1 | Opposite bus accepts request |
| m_req_tag | output | TAGW | Entry number of the request |
| m_req_addr | output | AW | Request address |
| m_req_cmd | output | 4 | Request command |
| m_req_be | output | 4 | Request byte enables |
| m_req_par | output | 1 | Request address parity |
| c_valid | input | 1 | Completion present |
| c_tag | input | TAGW | Entry the completion belongs to |
| c_status | input | 2 | 00 data, 01 target abort, 10 master abort |
| c_data | input | DW | Completion read data |

## Verification
A completion landing on an entry and a repeat of the same read can fall in the same cycle. The bench provokes this by raising `c_valid` for the waiting entry in the very cycle the repeat's `t_irdy` is high. The block must judge the repeat against the entry state before the update, so the scoreboard expects a retry for that attempt and the completed data on the next identical attempt. A second overlap places completion collection against the discard window: an entry left uncollected past the limit is judged by a fresh retry and a new request.

// File: rtl/dr_pkg.sv
package dr_pkg;

    localparam int CMD_W = 4;
    localparam int BE_W  = 4;

    typedef enum logic [1:0] {
        ENT_FREE,
        ENT_PEND,
        ENT_ISSUED,
        ENT_READY
    } ent_state_e;

    typedef enum logic [1:0] {
        CPL_OK     = 2'b00,
        CPL_TABORT = 2'b01,
        CPL_MABORT = 2'b10,
        CPL_RSVD   = 2'b11
    } cpl_status_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [BE_W-1:0]  be;
        logic             par;
    } req_ctl_t;

    function automatic logic is_data(cpl_status_e s);
        return s == CPL_OK;
    endfunction

endpackage

// File: rtl/dr_pick_first.sv
module dr_pick_first #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dr_entry.sv
module dr_entry
    import dr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LIMIT = 32768,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        alloc,
    input  logic [AW-1:0] alloc_addr,
    input  req_ctl_t    alloc_ctl,
    input  logic        issued,
    input  logic        cpl_hit,
    input  cpl_status_e cpl_status,
    input  logic [DW-1:0] cpl_data,
    input  logic        consume,
    output ent_state_e  state,
    output logic [AW-1:0] addr,
    output req_ctl_t    ctl,
    output cpl_status_e status,
    output logic [DW-1:0] data
);
    logic [TW-1:0] age;
    logic          expire;

    assign expire = (state == ENT_READY) && (age == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENT_FREE;
            age   <= '0;
        end else begin
            case (state)
                ENT_FREE: if (alloc) begin
                    state <= ENT_PEND;
                    addr  <= alloc_addr;
                    ctl   <= alloc_ctl;
                end
                ENT_PEND: if (issued) state <= ENT_ISSUED;
                ENT_ISSUED: if (cpl_hit) begin
                    state  <= ENT_READY;
                    status <= cpl_status;
                    data   <= cpl_data;
                    age    <= '0;
                end
                ENT_READY: begin
                    if (consume || expire) state <= ENT_FREE;
                    else                   age   <= age + 1'b1;
                end
                default: state <= ENT_FREE;
            endcase
        end
    end
endmodule

// File: rtl/dr_read_capture.sv
module dr_read_capture
    import dr_pkg::*;
#(
    parameter int AW            = 32,
    parameter int DW            = 32,
    parameter int NENT          = 3,
    parameter int DISCARD_LIMIT = 32768,
    localparam int TAGW         = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            t_start,
    input  logic [AW-1:0]   t_addr,
    input  logic [CMD_W-1:0] t_cmd,
    input  logic            t_par,
    input  logic            t_irdy,
    input  logic [BE_W-1:0] t_be,
    output logic            t_retry,
    output logic            t_ack,
    output logic            t_tabort,
    output logic            t_mabort,
    output logic [DW-1:0]   t_rdata,
    output logic            m_req_valid,
    input  logic            m_req_ready,
    output logic [TAGW-1:0] m_req_tag,
    output logic [AW-1:0]   m_req_addr,
    output logic [CMD_W-1:0] m_req_cmd,
    output logic [BE_W-1:0] m_req_be,
    output logic            m_req_par,
    input  logic            c_valid,
    input  logic [TAGW-1:0] c_tag,
    input  logic [1:0]      c_status,
    input  logic [DW-1:0]   c_data
);
    // address-phase capture
    logic             cap_busy;
    logic [AW-1:0]    cap_addr;
    logic [CMD_W-1:0] cap_cmd;
    logic             cap_par;
    logic             decide;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_busy <= 1'b0;
        end else if (t_start) begin
            cap_busy <= 1'b1;
            cap_addr <= t_addr;
            cap_cmd  <= t_cmd;
            cap_par  <= t_par;
        end else if (t_irdy) begin
            cap_busy <= 1'b0;
        end
    end

    assign decide = cap_busy && t_irdy && !t_start;

    // entry array
    ent_state_e    ent_state [NENT];
    logic [AW-1:0] ent_addr  [NENT];
    req_ctl_t      ent_ctl   [NENT];
    cpl_status_e   ent_stat  [NENT];
    logic [DW-1:0] ent_data  [NENT];

    logic [NENT-1:0] free_v, pend_v, hit_v, alloc_v, consume_v, issue_v, cplhit_v;
    logic            free_any, pend_any, hit_any, hit_ready;
    logic [TAGW-1:0] free_idx, pend_idx, hit_idx, sel_idx;
    logic            hold_v;
    logic [TAGW-1:0] hold_idx;
    req_ctl_t        new_ctl;

    assign new_ctl = '{cmd: cap_cmd, be: t_be, par: cap_par};

    dr_pick_first #(.N(NENT)) u_pick_free (.req(free_v), .any(free_any), .idx(free_idx));
    dr_pick_first #(.N(NENT)) u_pick_pend (.req(pend_v), .any(pend_any), .idx(pend_idx));
    dr_pick_first #(.N(NENT)) u_pick_hit  (.req(hit_v),  .any(hit_any),  .idx(hit_idx));

    assign hit_ready = hit_any && (ent_state[hit_idx] == ENT_READY);

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        dr_entry #(.AW(AW), .DW(DW), .LIMIT(DISCARD_LIMIT)) u_ent (
            .clk        (clk),
            .rst        (rst),
            .alloc      (alloc_v[g]),
            .alloc_addr (cap_addr),
            .alloc_ctl  (new_ctl),
            .issued     (issue_v[g]),
            .cpl_hit    (cplhit_v[g]),
            .cpl_status (cpl_status_e'(c_status)),
            .cpl_data   (c_data),
            .consume    (consume_v[g]),
            .state      (ent_state[g]),
            .addr       (ent_addr[g]),
            .ctl        (ent_ctl[g]),
            .status     (ent_stat[g]),
            .data       (ent_data[g])
        );
        assign free_v[g]    = (ent_state[g] == ENT_FREE);
        assign pend_v[g]    = (ent_state[g] == ENT_PEND);
        assign hit_v[g]     = !free_v[g] && (ent_addr[g] == cap_addr) &&
                              (ent_ctl[g].cmd == cap_cmd) && (ent_ctl[g].be == t_be);
        assign alloc_v[g]   = decide && !hit_any && free_any && (free_idx == TAGW'(g));
        assign consume_v[g] = decide && hit_ready && (hit_idx == TAGW'(g));
        assign issue_v[g]   = m_req_valid && m_req_ready && (sel_idx == TAGW'(g));
        assign cplhit_v[g]  = c_valid && (c_tag == TAGW'(g));
    end

    // request port: keep the offered entry while stalled
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
        end else begin
            hold_v   <= m_req_valid && !m_req_ready;
            hold_idx <= sel_idx;
        end
    end

    assign sel_idx     = hold_v ? hold_idx : pend_idx;
    assign m_req_valid = pend_any;
    assign m_req_tag   = sel_idx;
    assign m_req_addr  = ent_addr[sel_idx];
    assign m_req_cmd   = ent_ctl[sel_idx].cmd;
    assign m_req_be    = ent_ctl[sel_idx].be;
    assign m_req_par   = ent_ctl[sel_idx].par;

    // registered termination
    always_ff @(posedge clk) begin
        if (rst) begin
            t_retry  <= 1'b0;
            t_ack    <= 1'b0;
            t_tabort <= 1'b0;
            t_mabort <= 1'b0;
            t_rdata  <= '0;
        end else begin
            t_retry  <= decide && !hit_ready;
            t_ack    <= decide && hit_ready && is_data(ent_stat[hit_idx]);
            t_tabort <= decide && hit_ready && (ent_stat[hit_idx] == CPL_TABORT);
            t_mabort <= decide && hit_ready && (ent_stat[hit_idx] == CPL_MABORT);
            t_rdata  <= ent_data[hit_idx];
        end
    end
endmodule

// File: rtl/dr_chk.sv
module dr_chk #(
    parameter int AW   = 32,
    parameter int TAGW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            t_irdy,
    input logic            t_retry,
    input logic            t_ack,
    input logic            t_tabort,
    input logic            t_mabort,
    input logic            m_req_valid,
    input logic            m_req_ready,
    input logic [TAGW-1:0] m_req_tag,
    input logic [AW-1:0]   m_req_addr
);
    // R1
    resp_after_irdy_chk: assert property (@(posedge clk) disable iff (rst)
        (t_retry || t_ack || t_tabort || t_mabort) |-> $past(t_irdy));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid && !m_req_ready) |=>
            (m_req_valid && $stable(m_req_tag) && $stable(m_req_addr)));

    // R10
    resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({t_retry, t_ack, t_tabort, t_mabort}));

    // R10
    quiet_after_reset_chk: assert property (@(posedge clk)
        rst |=> !(t_retry || t_ack || t_tabort || t_mabort || m_req_valid));
endmodule

bind dr_read_capture dr_chk #(.AW(AW), .TAGW(TAGW)) u_dr_chk (
    .clk         (clk),
    .rst         (rst),
    .t_irdy      (t_irdy),
    .t_retry     (t_retry),
    .t_ack       (t_ack),
    .t_tabort    (t_tabort),
    .t_mabort    (t_mabort),
    .m_req_valid (m_req_valid),
    .m_req_ready (m_req_ready),
    .m_req_tag   (m_req_tag),
    .m_req_addr  (m_req_addr)
);

// File: tb/dr_read_capture_bench.sv
module dr_read_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic t_start = 0, t_par = 0, t_irdy = 0;
    logic [AW-1:0] t_addr = '0;
    logic [3:0] t_cmd = '0, t_be = '0;
    logic t_retry, t_ack, t_tabort, t_mabort;
    logic [DW-1:0] t_rdata;
    logic m_req_valid, m_req_par;
    logic m_req_ready = 0;
    logic [1:0] m_req_tag;
    logic [AW-1:0] m_req_addr;
    logic [3:0] m_req_cmd, m_req_be;
    logic c_valid = 0;
    logic [1:0] c_tag = '0, c_status = '0;
    logic [DW-1:0] c_data = '0;

    int checks = 0, failures = 0;
    bit finished = 0;
    string phase = "R10";

    int exp_kind[$];
    logic [DW-1:0] exp_data[$];
    string exp_rq[$];
    logic [42:0] exp_req[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dr_read_capture #(.AW(AW), .DW(DW), .NENT(3), .DISCARD_LIMIT(16)) u_dr_read_capture (
        .clk(clk), .rst(rst), .t_start(t_start), .t_addr(t_addr), .t_cmd(t_cmd),
        .t_par(t_par), .t_irdy(t_irdy), .t_be(t_be), .t_retry(t_retry), .t_ack(t_ack),
        .t_tabort(t_tabort), .t_mabort(t_mabort), .t_rdata(t_rdata),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_tag(m_req_tag),
        .m_req_addr(m_req_addr), .m_req_cmd(m_req_cmd), .m_req_be(m_req_be),
        .m_req_par(m_req_par), .c_valid(c_valid), .c_tag(c_tag), .c_status(c_status),
        .c_data(c_data)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // driver: one read attempt, pushes the expected termination
    task automatic attempt(input logic [AW-1:0] a, input logic [3:0] c, input logic p,
                           input logic [3:0] be, input int kind, input logic [DW-1:0] d,
                           input string rq, input bit with_cpl = 0,
                           input logic [1:0] ctag = 0, input logic [DW-1:0] cdat = 0);
        @(negedge clk);
        t_start = 1; t_addr = a; t_cmd = c; t_par = p; t_be = ~be;
        @(negedge clk);
        t_start = 0; t_addr = ~a; t_cmd = ~c; t_par = ~p; t_irdy = 1; t_be = be;
        if (with_cpl) begin
            c_valid = 1; c_tag = ctag; c_status = 2'b00; c_data = cdat;
        end
        exp_kind.push_back(kind); exp_data.push_back(d); exp_rq.push_back(rq);
        @(negedge clk);
        t_irdy = 0; t_be = '0; c_valid = 0;
    endtask

    task automatic expect_req(input logic [AW-1:0] a, input logic [3:0] c,
                              input logic [3:0] be, input logic p, input logic [1:0] tag);
        exp_req.push_back({a, c, be, p, tag});
    endtask

    task automatic send_cpl(input logic [1:0] tag, input logic [1:0] st, input logic [DW-1:0] d);
        @(negedge clk);
        c_valid = 1; c_tag = tag; c_status = st; c_data = d;
        @(negedge clk);
        c_valid = 0;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 m_req_ready = v;
    endtask

    // monitor: terminations
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int k;
            k = t_retry ? 1 : t_ack ? 2 : t_tabort ? 3 : t_mabort ? 4 : 0;
            if ($countones({t_retry, t_ack, t_tabort, t_mabort}) > 1)
                check(0, "R10", "several terminations", {t_retry, t_ack, t_tabort, t_mabort}, 0);
            if (k != 0) begin
                if (exp_kind.size() == 0) begin
                    check(0, "R10", "unexpected termination", k, 0);
                end else begin
                    int ek;
                    logic [DW-1:0] ed;
                    string rq;
                    ek = exp_kind.pop_front(); ed = exp_data.pop_front(); rq = exp_rq.pop_front();
                    check(k == ek, rq, "termination kind", k, ek);
                    if (ek == 2) check(t_rdata == ed, rq, "read data", t_rdata, ed);
                end
            end
        end
    end

    // monitor: requests toward the opposite bus
    always @(negedge clk) begin
        if (!rst && !finished && m_req_valid && m_req_ready) begin
            logic [42:0] act;
            act = {m_req_addr, m_req_cmd, m_req_be, m_req_par, m_req_tag};
            if (exp_req.size() == 0) begin
                check(0, phase, "unexpected request", act, 0);
            end else begin
                logic [42:0] e;
                e = exp_req.pop_front();
                check(act == e, "R1", "request fields (R2 be, R3 tag)", act, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check({t_retry, t_ack, t_tabort, t_mabort, m_req_valid} == 5'b0, "R10",
              "outputs after reset", {t_retry, t_ack, t_tabort, t_mabort, m_req_valid}, 0);

        // R1/R2: first attempt, request held while stalled (R3)
        phase = "R1";
        expect_req(32'h100, 4'h6, 4'h3, 1'b1, 2'd0);
        attempt(32'h100, 4'h6, 1'b1, 4'h3, 1, 0, "R1");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(m_req_valid && m_req_tag == 2'd0, "R3", "request held while stalled",
                  {m_req_valid, m_req_tag}, 3'b100);
        end
        set_ready(1);
        repeat (2) @(negedge clk);

        // R4: repeat before completion
        phase = "R4";
        attempt(32'h100, 4'h6, 1'b1, 4'h3, 1, 0, "R4");
        repeat (2) @(negedge clk);

        // R5: data delivered, then entry free
        phase = "R5";
        send_cpl(2'd0, 2'b00, 32'hDEADBEEF);
        attempt(32'h100, 4'h6, 1'b1, 4'h3, 2, 32'hDEADBEEF, "R5");
        expect_req(32'h100, 4'h6, 4'h3, 1'b1, 2'd0);
        attempt(32'h100, 4'h6, 1'b1, 4'h3, 1, 0, "R5");
        repeat (2) @(negedge clk);

        // R8: discard after the limit
        phase = "R8";
        send_cpl(2'd0, 2'b00, 32'h11111111);
        repeat (20) @(negedge clk);
        expect_req(32'h100, 4'h6, 4'h3, 1'b1, 2'd0);
        attempt(32'h100, 4'h6, 1'b1, 4'h3, 1, 0, "R8");
        repeat (2) @(negedge clk);

        // R6: target abort
        phase = "R6";
        send_cpl(2'd0, 2'b01, 32'h0);
        attempt(32'h100, 4'h6, 1'b1, 4'h3, 3, 0, "R6");

        // R7: distinct reads fill the entries, then full
        phase = "R7";
        expect_req(32'h200, 4'h6, 4'hF, 1'b0, 2'd0);
        attempt(32'h200, 4'h6, 1'b0, 4'hF, 1, 0, "R7");
        expect_req(32'h200, 4'hC, 4'hF, 1'b0, 2'd1);
        attempt(32'h200, 4'hC, 1'b0, 4'hF, 1, 0, "R7");
        expect_req(32'h200, 4'h6, 4'hE, 1'b0, 2'd2);
        attempt(32'h200, 4'h6, 1'b0, 4'hE, 1, 0, "R7");
        attempt(32'h300, 4'h6, 1'b0, 4'hF, 1, 0, "R7");
        repeat (3) @(negedge clk);

        // R6: master abort on entry 1, freed entry reused
        phase = "R6";
        send_cpl(2'd1, 2'b10, 32'h0);
        attempt(32'h200, 4'hC, 1'b0, 4'hF, 4, 0, "R6");
        expect_req(32'h300, 4'h6, 4'hF, 1'b0, 2'd1);
        attempt(32'h300, 4'h6, 1'b0, 4'hF, 1, 0, "R6");
        repeat (2) @(negedge clk);

        // R9: completion in the same cycle as the matching repeat
        phase = "R9";
        attempt(32'h200, 4'h6, 1'b0, 4'hF, 1, 0, "R9", 1, 2'd0, 32'hCAFE0001);
        attempt(32'h200, 4'h6, 1'b0, 4'hF, 2, 32'hCAFE0001, "R9");

        repeat (5) @(negedge clk);
        check(exp_kind.size() == 0, "R10", "terminations outstanding", exp_kind.size(), 0);
        check(exp_req.size() == 0, "R3", "requests outstanding", exp_req.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule